// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns one read or write request from an on-chip master into a single memory-style cycle on an external bus. Each access runs through a fixed sequence of phases:
- an access-start cycle, in which nothing is asserted;
- a wait window whose length is programmable;
- a wait-end cycle that closes the window;
- for some accesses, a few trailing cycles before the bus goes idle.

The timing of an access comes from a configuration word that is sampled when the request is accepted. It sets the window length, one assert delay for each of the four active-low controls (chip select, read strobe, write strobe, write-data drive), and the trailing counts. The read and write strobes always release together right after the wait-end cycle. On writes, chip select and data drive can stay asserted into the trailing cycles. A write-direction output follows chip select on writes.

The master sees `rdy_o` go low while an access is in flight and a one-cycle `done_o` when the access is over. Read data is captured at the close of the wait-end cycle. An assert delay longer than the window is clamped to the window, and this raises a sticky configuration error flag.

Top module: `xbus_cycle_seq`

## Requirements
- R1: `rdy_o` is high when idle. A request seen at a clock edge with `rdy_o` high starts an access. The next cycle is the access-start cycle: `rdy_o` is low, `cs_n_o`, `rd_n_o`, `we_n_o`, `wd_n_o` and `dir_wr_n_o` are all high, and `bus_addr_o` still shows its previous value.
- R2: `bus_addr_o`, `bus_be_o` and `bus_wdata_o` take the request's values in the first cycle after access start. They hold those values until the next access changes them.
- R3: The configuration word is laid out as follows. Bits [4:0] give the window length W (0..31). Bits [7:5], [10:8], [13:11] and [16:14] give the assert delays for chip select, read strobe, write strobe and data drive. Bits [18:17] give the write chip-select trailing count, bits [20:19] the write data trailing count, and bits [22:21] the read trailing count. Window cycles are numbered 1..W+1 after access start, and cycle W+1 is the wait-end cycle. `rdy_o` stays low for W+2+T cycles, where T is the trailing length.
- R4: A control with assert delay A is low in window cycle k exactly when k > A. Chip select applies to both directions, the read strobe to reads only, and the write strobe and data drive to writes only.
- R5: `rd_n_o` and `we_n_o` are high from the cycle after wait-end onward.
- R6: On a write, T is the larger of the two write trailing counts. In trailing cycle j, `cs_n_o` is low when j is at most the chip-select count, and `wd_n_o` is low when j is at most the data count. On a read, T is the read trailing count and every control is high in those cycles.
- R7: `dir_wr_n_o` is low exactly when `cs_n_o` is low during a write, and it is always high on reads.
- R8: On a read, `rdata_o` takes `rdata_i` at the clock edge that ends the wait-end cycle. It then holds that value until the next read captures.
- R9: `done_o` pulses for exactly one cycle, in the first cycle after the access. `rdy_o` is high in that cycle, and a request presented then is accepted.
- R10: An assert delay greater than W behaves as W and sets `cfg_err_o`. The flag stays set until reset, and valid settings never set it.
- R11: A request presented while `rdy_o` is low is ignored.
- R12: Reset, which is asynchronous and active-low, gives `rdy_o`=1, `done_o`=0, `cfg_err_o`=0, all controls high, and zero on the address and read data outputs, even in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | ADDR_W | Request address |
| be_i | input | DATA_W/8 | Request byte enables |
| wdata_i | input | DATA_W | Request write data |
| cfg_i | input | 23 | Timing configuration word (R3) |
| rdata_i | input | DATA_W | Data from external bus |
| rdy_o | output | 1 | Idle, request may be accepted |
| done_o | output | 1 | One-cycle completion pulse |
| cfg_err_o | output | 1 | Sticky clamped-configuration flag |
| rdata_o | output | DATA_W | Captured read data |
| bus_addr_o | output | ADDR_W | External address |
| bus_be_o | output | DATA_W/8 | External byte controls |
| bus_wdata_o | output | DATA_W | External write data |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| we_n_o | output | 1 | Write strobe, active low |
| wd_n_o | output | 1 | Write-data drive, active low |
| dir_wr_n_o | output | 1 | Write direction, active low, chip-select timed |

## Verification
Completion and acceptance of the next request can happen in the same cycle. The bench provokes this by presenting a new request in the cycle where `done_o` is high. The following cycle must then be an access start: `rdy_o` low, every control high, and the old address still on the bus. A second overlap comes from a clamped configuration with a short window. There, every assert delay collapses onto the wait-end cycle, so each enabled control asserts in the same cycle as the read-data capture edge. The bench judges this from its own cycle-by-cycle model of the controls and from the captured data value.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int WAIT_W = 5;
    localparam int AW_W   = 3;
    localparam int TR_W   = 2;
    localparam int NUM_AW = 4;

    localparam int ST_CS = 0;
    localparam int ST_RD = 1;
    localparam int ST_WR = 2;
    localparam int ST_WD = 3;

    localparam int AW_LSB = WAIT_W;
    localparam int TR_LSB = WAIT_W + NUM_AW * AW_W;
    localparam int CFG_W  = TR_LSB + 3 * TR_W;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_WAIT  = 2'd2,
        PH_TRAIL = 2'd3
    } phase_e;

    typedef struct packed {
        logic [WAIT_W-1:0]            wait_n;
        logic [NUM_AW-1:0][AW_W-1:0]  aw;
        logic [TR_W-1:0]              cs_tr;
        logic [TR_W-1:0]              wd_tr;
        logic [TR_W-1:0]              rd_tr;
        logic                         bad;
    } timing_t;
endpackage

// File: rtl/xbus_cfg_decode.sv
module xbus_cfg_decode
    import xbus_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_i,
    output timing_t          tim_o
);
    logic [WAIT_W-1:0] win;
    logic [NUM_AW-1:0] over;
    logic [AW_W-1:0]   raw;

    always_comb begin
        win   = cfg_i[WAIT_W-1:0];
        tim_o = '0;
        over  = '0;
        raw   = '0;
        tim_o.wait_n = win;
        for (int g = 0; g < NUM_AW; g++) begin
            raw         = cfg_i[AW_LSB + g*AW_W +: AW_W];
            over[g]     = WAIT_W'(raw) > win;
            tim_o.aw[g] = over[g] ? win[AW_W-1:0] : raw;
        end
        tim_o.cs_tr = cfg_i[TR_LSB +: TR_W];
        tim_o.wd_tr = cfg_i[TR_LSB + TR_W +: TR_W];
        tim_o.rd_tr = cfg_i[TR_LSB + 2*TR_W +: TR_W];
        tim_o.bad   = |over;
    end
endmodule

// File: rtl/xbus_strobe_gate.sv
module xbus_strobe_gate #(
    parameter int CNT_W = 6,
    parameter int AW_W  = 3,
    parameter int TR_W  = 2
) (
    input  logic             enable,
    input  logic             in_win,
    input  logic             in_trail,
    input  logic [CNT_W-1:0] win_idx,
    input  logic [AW_W-1:0]  aw,
    input  logic [TR_W-1:0]  trail_idx,
    input  logic [TR_W-1:0]  trail_len,
    output logic             act
);
    logic win_hit;
    logic trail_hit;

    always_comb begin
        win_hit   = in_win && (win_idx > CNT_W'(aw));
        trail_hit = in_trail && (trail_idx <= trail_len);
        act       = enable && (win_hit || trail_hit);
    end
endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_i,
    input  logic                  rd_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W/8-1:0]   be_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [CFG_W-1:0]      cfg_i,
    input  logic [DATA_W-1:0]     rdata_i,
    output logic                  rdy_o,
    output logic                  done_o,
    output logic                  cfg_err_o,
    output logic [DATA_W-1:0]     rdata_o,
    output logic [ADDR_W-1:0]     bus_addr_o,
    output logic [DATA_W/8-1:0]   bus_be_o,
    output logic [DATA_W-1:0]     bus_wdata_o,
    output logic                  cs_n_o,
    output logic                  rd_n_o,
    output logic                  we_n_o,
    output logic                  wd_n_o,
    output logic                  dir_wr_n_o
);
    localparam int BE_W  = DATA_W / 8;
    localparam int CNT_W = WAIT_W + 1;

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        timing_t            tim;
        logic               is_rd;
        logic [ADDR_W-1:0]  addr_h;
        logic [BE_W-1:0]    be_h;
        logic [DATA_W-1:0]  wd_h;
        logic [ADDR_W-1:0]  addr;
        logic [BE_W-1:0]    be;
        logic [DATA_W-1:0]  wd;
        logic [DATA_W-1:0]  rdata;
        logic               done;
        logic               err;
    } seq_t;

    seq_t q, d;

    timing_t tim_dec;
    logic [TR_W-1:0]  trail_len;
    logic [CNT_W-1:0] wend_idx;

    logic [NUM_AW-1:0]            act_d, act_q;
    logic [NUM_AW-1:0]            g_en;
    logic [NUM_AW-1:0][TR_W-1:0]  g_tl;
    logic                         dir_d, dir_q;

    xbus_cfg_decode u_dec (
        .cfg_i (cfg_i),
        .tim_o (tim_dec)
    );

    // Trailing length and wait-end index of the access in flight
    always_comb begin
        if (q.is_rd) begin
            trail_len = q.tim.rd_tr;
        end else begin
            trail_len = (q.tim.cs_tr > q.tim.wd_tr) ? q.tim.cs_tr : q.tim.wd_tr;
        end
        wend_idx = {1'b0, q.tim.wait_n} + CNT_W'(1);
    end

    // Phase sequencing: all next-state values
    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (req_i) begin
                    d.ph     = PH_START;
                    d.cnt    = '0;
                    d.tim    = tim_dec;
                    d.is_rd  = rd_i;
                    d.addr_h = addr_i;
                    d.be_h   = be_i;
                    d.wd_h   = wdata_i;
                    d.err    = q.err | tim_dec.bad;
                end
            end
            PH_START: begin
                d.ph   = PH_WAIT;
                d.cnt  = CNT_W'(1);
                d.addr = q.addr_h;
                d.be   = q.be_h;
                d.wd   = q.wd_h;
            end
            PH_WAIT: begin
                if (q.cnt == wend_idx) begin
                    if (q.is_rd) begin
                        d.rdata = rdata_i;
                    end
                    if (trail_len != '0) begin
                        d.ph  = PH_TRAIL;
                        d.cnt = CNT_W'(1);
                    end else begin
                        d.ph   = PH_IDLE;
                        d.done = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            PH_TRAIL: begin
                if (q.cnt == CNT_W'(trail_len)) begin
                    d.ph   = PH_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    // Per-control direction enable and trailing extent
    always_comb begin
        g_en[ST_CS] = 1'b1;
        g_en[ST_RD] = d.is_rd;
        g_en[ST_WR] = !d.is_rd;
        g_en[ST_WD] = !d.is_rd;
        g_tl[ST_CS] = d.is_rd ? '0 : d.tim.cs_tr;
        g_tl[ST_RD] = '0;
        g_tl[ST_WR] = '0;
        g_tl[ST_WD] = d.tim.wd_tr;
    end

    for (genvar g = 0; g < NUM_AW; g++) begin : g_strobe
        xbus_strobe_gate #(
            .CNT_W (CNT_W),
            .AW_W  (AW_W),
            .TR_W  (TR_W)
        ) u_gate (
            .enable    (g_en[g]),
            .in_win    (d.ph == PH_WAIT),
            .in_trail  (d.ph == PH_TRAIL),
            .win_idx   (d.cnt),
            .aw        (d.tim.aw[g]),
            .trail_idx (d.cnt[TR_W-1:0]),
            .trail_len (g_tl[g]),
            .act       (act_d[g])
        );
    end

    assign dir_d = act_d[ST_CS] && !d.is_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            act_q <= '0;
            dir_q <= 1'b0;
        end else begin
            q     <= d;
            act_q <= act_d;
            dir_q <= dir_d;
        end
    end

    assign rdy_o       = (q.ph == PH_IDLE);
    assign done_o      = q.done;
    assign cfg_err_o   = q.err;
    assign rdata_o     = q.rdata;
    assign bus_addr_o  = q.addr;
    assign bus_be_o    = q.be;
    assign bus_wdata_o = q.wd;
    assign cs_n_o      = !act_q[ST_CS];
    assign rd_n_o      = !act_q[ST_RD];
    assign we_n_o      = !act_q[ST_WR];
    assign wd_n_o      = !act_q[ST_WD];
    assign dir_wr_n_o  = !dir_q;
endmodule

// File: rtl/xbus_cycle_seq_chk.sv
module xbus_cycle_seq_chk #(
    parameter int ADDR_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rdy_o,
    input logic              done_o,
    input logic              cfg_err_o,
    input logic              cs_n_o,
    input logic              rd_n_o,
    input logic              we_n_o,
    input logic              wd_n_o,
    input logic              dir_wr_n_o,
    input logic [ADDR_W-1:0] bus_addr_o
);
    a_r1_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_o) |-> (cs_n_o && rd_n_o && we_n_o && wd_n_o && dir_wr_n_o));

    a_r1_start_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_o) |-> $stable(bus_addr_o));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> (cs_n_o && rd_n_o && we_n_o && wd_n_o));

    a_r4_rd_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !we_n_o));

    a_r7_dir_within_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_wr_n_o |-> !cs_n_o);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_done_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> rdy_o);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> cfg_err_o);
endmodule

bind xbus_cycle_seq xbus_cycle_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rdy_o      (rdy_o),
    .done_o     (done_o),
    .cfg_err_o  (cfg_err_o),
    .cs_n_o     (cs_n_o),
    .rd_n_o     (rd_n_o),
    .we_n_o     (we_n_o),
    .wd_n_o     (wd_n_o),
    .dir_wr_n_o (dir_wr_n_o),
    .bus_addr_o (bus_addr_o)
);

// File: tb/tb_xbus_cycle_seq.sv
module tb_xbus_cycle_seq;
    import xbus_pkg::*;

    localparam int ADDR_W = 26;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               req_i = 1'b0;
    logic               rd_i = 1'b0;
    logic [ADDR_W-1:0]  addr_i = '0;
    logic [BE_W-1:0]    be_i = '0;
    logic [DATA_W-1:0]  wdata_i = '0;
    logic [CFG_W-1:0]   cfg_i = '0;
    logic [DATA_W-1:0]  rdata_i = '0;
    logic               rdy_o, done_o, cfg_err_o;
    logic [DATA_W-1:0]  rdata_o, bus_wdata_o;
    logic [ADDR_W-1:0]  bus_addr_o;
    logic [BE_W-1:0]    bus_be_o;
    logic               cs_n_o, rd_n_o, we_n_o, wd_n_o, dir_wr_n_o;

    xbus_cycle_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .rd_i(rd_i), .addr_i(addr_i),
        .be_i(be_i), .wdata_i(wdata_i), .cfg_i(cfg_i), .rdata_i(rdata_i),
        .rdy_o(rdy_o), .done_o(done_o), .cfg_err_o(cfg_err_o), .rdata_o(rdata_o),
        .bus_addr_o(bus_addr_o), .bus_be_o(bus_be_o), .bus_wdata_o(bus_wdata_o),
        .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .we_n_o(we_n_o), .wd_n_o(wd_n_o),
        .dir_wr_n_o(dir_wr_n_o)
    );

    typedef struct packed {
        logic        is_rd;
        logic [4:0]  w;
        logic [2:0]  acs, ard, awr, awd;
        logic [1:0]  tcs, twd, trd;
        logic [25:0] addr;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] rbase;
        logic [7:0]  len;
    } vec_t;

    // stimulus and expected busy length (W + 2 + T)
    localparam vec_t VEC [7] = '{
        '{1'b1, 5'd3,  3'd0, 3'd1, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 26'h0123456, 4'hF, 32'h00000000, 32'hA0000000, 8'd5},
        '{1'b0, 5'd4,  3'd1, 3'd0, 3'd2, 3'd0, 2'd2, 2'd1, 2'd0, 26'h2AAAAAA, 4'h3, 32'hDEADBEEF, 32'h00000000, 8'd8},
        '{1'b0, 5'd0,  3'd0, 3'd0, 3'd0, 3'd0, 2'd0, 2'd3, 2'd0, 26'h1555555, 4'h1, 32'h12345678, 32'h00000000, 8'd5},
        '{1'b1, 5'd7,  3'd2, 3'd5, 3'd0, 3'd0, 2'd0, 2'd0, 2'd3, 26'h3FFFFFF, 4'hC, 32'h00000000, 32'hB0000000, 8'd12},
        '{1'b0, 5'd31, 3'd7, 3'd7, 3'd7, 3'd3, 2'd1, 2'd0, 2'd2, 26'h0000040, 4'hF, 32'hCAFEF00D, 32'h00000000, 8'd34},
        '{1'b1, 5'd0,  3'd0, 3'd0, 3'd0, 3'd0, 2'd0, 2'd0, 2'd1, 26'h00000FF, 4'h8, 32'h00000000, 32'hC0000000, 8'd3},
        '{1'b0, 5'd2,  3'd0, 3'd0, 3'd1, 3'd2, 2'd3, 2'd3, 2'd0, 26'h2000001, 4'h6, 32'h0F0F0F0F, 32'h00000000, 8'd7}
    };
    localparam vec_t V_LONG  = '{1'b0, 5'd10, 3'd1, 3'd0, 3'd1, 3'd1, 2'd0, 2'd0, 2'd0, 26'h0ABCDEF, 4'h5, 32'h55AA55AA, 32'h0, 8'd12};
    localparam vec_t V_OTHER = '{1'b1, 5'd1,  3'd0, 3'd0, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 26'h3333333, 4'hA, 32'h0, 32'h0, 8'd3};
    localparam vec_t V_CLAMP = '{1'b1, 5'd2,  3'd5, 3'd6, 3'd7, 3'd4, 2'd0, 2'd0, 2'd0, 26'h1234567, 4'h9, 32'h0, 32'hD0000000, 8'd4};

    int n_vec = 0;
    int n_bad = 0;
    bit fin = 1'b0;
    logic [ADDR_W-1:0] last_addr = '0;
    logic [DATA_W-1:0] last_rd = '0;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input vec_t v);
        req_i   = 1'b1;
        rd_i    = v.is_rd;
        addr_i  = v.addr;
        be_i    = v.be;
        wdata_i = v.wd;
        cfg_i   = {v.trd, v.twd, v.tcs, v.awd, v.awr, v.ard, v.acs, v.w};
    endtask

    task automatic idle_quiet(input string tag);
        check(tag, "rdy", 64'(rdy_o), 64'd1);
        check(tag, "ctl", 64'({cs_n_o, rd_n_o, we_n_o, wd_n_o, dir_wr_n_o}), 64'h1F);
    endtask

    // Walks one access from the edge that accepts it up to its done cycle
    task automatic follow(input vec_t v);
        int w, a_cs, a_rd, a_wr, a_wd, t, last, busy, j;
        bit e_cs, e_rd, e_we, e_wd;
        string tag, tag_rw;
        logic [DATA_W-1:0] exp_rd;
        w    = int'(v.w);
        a_cs = (int'(v.acs) > w) ? w : int'(v.acs);
        a_rd = (int'(v.ard) > w) ? w : int'(v.ard);
        a_wr = (int'(v.awr) > w) ? w : int'(v.awr);
        a_wd = (int'(v.awd) > w) ? w : int'(v.awd);
        if (v.is_rd) t = int'(v.trd);
        else         t = (v.tcs > v.twd) ? int'(v.tcs) : int'(v.twd);
        last   = w + 2 + t;
        busy   = 0;
        exp_rd = v.is_rd ? (v.rbase + 32'(w + 1)) : last_rd;
        @(negedge clk);
        req_i = 1'b0;
        for (int c = 0; c <= last; c++) begin
            e_cs = 0; e_rd = 0; e_we = 0; e_wd = 0;
            if (c >= 1 && c <= w + 1) begin
                e_cs = c > a_cs;
                e_rd = v.is_rd && (c > a_rd);
                e_we = !v.is_rd && (c > a_wr);
                e_wd = !v.is_rd && (c > a_wd);
            end else if (c > w + 1 && c < last) begin
                j    = c - w - 1;
                e_cs = !v.is_rd && (j <= int'(v.tcs));
                e_wd = !v.is_rd && (j <= int'(v.twd));
            end
            tag    = (c == 0) ? "R1" : (c <= w + 1) ? "R4" : (c < last) ? "R6" : "R9";
            tag_rw = (c > w + 1) ? "R5" : tag;
            check(tag, "cs_n", 64'(cs_n_o), 64'(!e_cs));
            check(tag_rw, "rd_n", 64'(rd_n_o), 64'(!e_rd));
            check(tag_rw, "we_n", 64'(we_n_o), 64'(!e_we));
            check(tag, "wd_n", 64'(wd_n_o), 64'(!e_wd));
            check("R7", "dir_wr_n", 64'(dir_wr_n_o), 64'(!(e_cs && !v.is_rd)));
            if (c == 0) check("R1", "addr", 64'(bus_addr_o), 64'(last_addr));
            else        check("R2", "addr/be/wdata", {2'b0, bus_addr_o, bus_be_o, bus_wdata_o},
                              {2'b0, v.addr, v.be, v.wd});
            if (c < last) begin
                check((c == 0) ? "R1" : "R3", "rdy", 64'(rdy_o), 64'd0);
                check("R9", "done", 64'(done_o), 64'd0);
                busy++;
            end else begin
                check("R9", "rdy", 64'(rdy_o), 64'd1);
                check("R9", "done", 64'(done_o), 64'd1);
                check("R8", "rdata", 64'(rdata_o), 64'(exp_rd));
                check("R3", "busy length", 64'(busy), 64'(v.len));
            end
            rdata_i = v.rbase + 32'(c);
            if (c < last) @(negedge clk);
        end
        last_addr = v.addr;
        last_rd   = exp_rd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle_quiet("R12");
        check("R12", "done", 64'(done_o), 64'd0);
        check("R12", "cfg_err", 64'(cfg_err_o), 64'd0);
        check("R12", "addr/rdata", {6'b0, bus_addr_o, rdata_o}, 64'd0);

        // Table walk
        for (int i = 0; i < 7; i++) begin
            issue(VEC[i]);
            follow(VEC[i]);
            @(negedge clk);
        end
        check("R10", "cfg_err after valid settings", 64'(cfg_err_o), 64'd0);

        // R9: request presented in the done cycle is accepted
        issue(VEC[1]);
        follow(VEC[1]);
        issue(VEC[5]);
        follow(VEC[5]);
        @(negedge clk);

        // R11: request while busy is ignored
        issue(V_LONG);
        @(negedge clk);
        req_i = 1'b0;
        repeat (3) @(negedge clk);
        issue(V_OTHER);
        repeat (2) @(negedge clk);
        req_i = 1'b0;
        while (!rdy_o) @(negedge clk);
        check("R11", "addr after busy request", 64'(bus_addr_o), 64'(V_LONG.addr));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            idle_quiet("R11");
        end
        check("R11", "addr unchanged", 64'(bus_addr_o), 64'(V_LONG.addr));
        last_addr = V_LONG.addr;

        // R10: clamped assert delays and sticky flag
        issue(V_CLAMP);
        follow(V_CLAMP);
        check("R10", "cfg_err set", 64'(cfg_err_o), 64'd1);
        @(negedge clk);
        issue(VEC[0]);
        follow(VEC[0]);
        check("R10", "cfg_err sticky", 64'(cfg_err_o), 64'd1);
        @(negedge clk);

        // R12: reset in the middle of an access
        issue(VEC[3]);
        @(negedge clk);
        req_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        #1;
        idle_quiet("R12");
        check("R12", "cfg_err cleared", 64'(cfg_err_o), 64'd0);
        check("R12", "addr/rdata cleared", {6'b0, bus_addr_o, rdata_o}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        last_addr = '0;
        last_rd   = '0;
        @(negedge clk);
        issue(VEC[2]);
        follow(VEC[2]);

        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule